// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block arbitrates sixteen numbered event levels for a processor core. Level 0 is the highest priority and level 15 the lowest. Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt and 3 is the exception level. Level 5 is hardware error, level 6 is the core timer, and levels 7 to 15 are general purpose. Slot 4 is not a level. In the in-service word it is the global disable flag.

Incoming requests are captured in a latch word and filtered by a mask word. An in-service word records every level that is active at once. When a request may preempt the current level, the block pulses a take strobe with the target level. The core then fetches the vector and saves the return address itself. The core reports returns, pushes and pops of its return address, and the block updates its nesting state from these. A per-level override word tells the core to use the reset vector for general-purpose levels. A word-addressed register port gives access to the override, mask, in-service, latch and priority words.

Top module: `evt_ctrl`

## Requirements
- R1: After synchronous reset the mask word reads 0x1F and the in-service word reads 0x12 (reset level plus the global disable flag). The latch, override and priority words read 0. `cur_lvl` is 1 and every strobe and flag is low.
- R2: The register words sit at byte offsets 0x00 (override), 0x04 (mask), 0x08 (in-service), 0x0C (latch) and 0x10 (priority). Read data appears on `reg_rdata` the cycle after `reg_rd`. An access whose byte enables are not all set, or whose address is not word aligned, writes nothing, and such a read returns 0.
- R3: A mask write updates bits 15..5 only, and bits 4..0 always read 1. Writes to the in-service word are ignored. The priority word keeps only bits 4..0 of the written value.
- R4: A latch write clears each latch bit that is written as 1 and lies in 0xFFEE. Latch bits 0 and 4 cannot be cleared this way.
- R5: `cur_lvl` is the lowest-numbered set in-service bit, ignoring bits 0 and 4. If no such bit is set it reads 16 (user level). It follows the in-service word with no extra delay.
- R6: Every request bit except bit 4 is latched, and a request on bit 4 is dropped. Only the lowest-numbered request in a cycle is evaluated. Requests for levels 0 and 1 are always taken, even while the global disable flag is set.
- R7: A request for level 2 or 3 while `cur_lvl` is less than or equal to that level pulses `dbl_fault` for one cycle. It takes nothing and leaves the latch bit set. Otherwise the request is taken.
- R8: A request for level 5 or above is not taken if the global disable flag is set and the core is not at user level. It is also not taken if its mask bit is clear. In both cases its latch bit stays set.
- R9: A take pulses `take_stb` for one cycle and gives the level on `take_lvl`. It sets that in-service bit and clears that latch bit. A take of level 5 or above also sets the global disable flag. `use_rst_vec` rises with the strobe when the override bit of a taken level 7 to 15 is set.
- R10: One cycle after a mask write, a return, a push, or a request that leaves a latch bit set, a deferred check runs unless the global disable flag is set. The check takes the lowest-numbered bit of latch AND mask if that level is below `cur_lvl`, or equal to it with `self_nest_en` high.
- R11: A return always clears in-service bit 0. A legal return clears the returned level's bit unless `ret_addr_lsb` is 1. It also clears the global disable flag when the returned level is 1 or 5 and above.
- R12: A return from level 0 is legal only at current level 0, from 2 only at 2, and from 3 only at 3. A return from 4 is never legal. A return from 1 or 5..15 is illegal at level 0, 2, 3 or user. An illegal return pulses `ret_illegal` and changes nothing but in-service bit 0.
- R13: A push command clears the global disable flag and schedules the deferred check. A pop command sets the global disable flag.
- R14: With `self_nest_en` high, a request equal to the current level is taken. With it low, the same request is only latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 16 | Event request per level, sampled each cycle |
| self_nest_en | input | 1 | Allows an event at the current level to nest |
| ret_cmd | input | 1 | Core returns from a level |
| ret_lvl | input | 4 | Level being returned from |
| ret_addr_lsb | input | 1 | Bit 0 of the saved return address (1 = self-nested return) |
| push_cmd | input | 1 | Core saved its return address; re-enables nesting |
| pop_cmd | input | 1 | Core restored its return address; disables nesting |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| reg_rdata | output | 32 | Registered read data |
| take_stb | output | 1 | One-cycle pulse: vector to `take_lvl` |
| take_lvl | output | 4 | Level being taken |
| use_rst_vec | output | 1 | Taken level must use the reset vector |
| dbl_fault | output | 1 | One-cycle double-fault pulse |
| ret_illegal | output | 1 | One-cycle illegal-return pulse |
| cur_lvl | output | 5 | Current level, 16 for user level |

## Verification
A request, return, push, pop or register write takes effect at the clock edge that samples it. `take_stb`, `dbl_fault`, `ret_illegal`, `cur_lvl` and the state words therefore reflect it just after that edge. A take reached through the deferred check appears one edge later, and `reg_rdata` also shows the state one edge after the read strobe. The bench drives each stimulus just after a rising edge. It samples 1 ns after the next edge, and adds exactly one more edge before checking a take expected from the deferred check. It also samples the cycle after each pulse to confirm it lasts one cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_LVL = 16;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int CUR_W   = LVL_W + 1;

  localparam int GDIS_IDX = 4;
  localparam int EMU_IDX  = 0;

  localparam logic [LVL_W-1:0] LV_EMU  = LVL_W'(0);
  localparam logic [LVL_W-1:0] LV_RST  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LV_NMI  = LVL_W'(2);
  localparam logic [LVL_W-1:0] LV_EXC  = LVL_W'(3);
  localparam logic [LVL_W-1:0] LV_GDIS = LVL_W'(4);
  localparam logic [LVL_W-1:0] LV_HWE  = LVL_W'(5);

  localparam logic [CUR_W-1:0] USER_LVL = CUR_W'(NUM_LVL);

  localparam logic [NUM_LVL-1:0] FIXED_MASK   = NUM_LVL'(16'h001F);
  localparam logic [NUM_LVL-1:0] LATCH_CLR_OK = NUM_LVL'(16'hFFEE);
  localparam logic [NUM_LVL-1:0] OVR_VALID    = NUM_LVL'(16'hFF80);
  localparam logic [NUM_LVL-1:0] PEND_RESET   = NUM_LVL'(16'h0012);
  localparam logic [NUM_LVL-1:0] NOT_A_LEVEL  = NUM_LVL'(16'h0011);

  typedef enum logic [2:0] {
    RS_OVR   = 3'd0,
    RS_MASK  = 3'd1,
    RS_PEND  = 3'd2,
    RS_LATCH = 3'd3,
    RS_PRIO  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // lowest-numbered set bit wins
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/evt_take_rule.sv
module evt_take_rule
  import evt_pkg::*;
(
  input  logic             valid,
  input  logic [LVL_W-1:0] lvl,
  input  logic [CUR_W-1:0] cur,
  input  logic             gdis,
  input  logic             mask_bit,
  input  logic             snen,
  output logic             take,
  output logic             dfault
);
  logic [CUR_W-1:0] lvl_x;
  assign lvl_x = {1'b0, lvl};

  always_comb begin
    take   = 1'b0;
    dfault = 1'b0;
    if (valid) begin
      if (lvl <= LV_RST) begin
        take = 1'b1;
      end else if (lvl <= LV_EXC) begin
        if (cur <= lvl_x) dfault = 1'b1;
        else              take   = 1'b1;
      end else if (lvl != LV_GDIS && !(gdis && cur != USER_LVL) && mask_bit &&
                   (lvl_x < cur || (snen && lvl_x == cur))) begin
        take = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LVL-1:0]    evt_req,
  input  logic                  self_nest_en,
  input  logic                  ret_cmd,
  input  logic [LVL_W-1:0]      ret_lvl,
  input  logic                  ret_addr_lsb,
  input  logic                  push_cmd,
  input  logic                  pop_cmd,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [DATA_W/8-1:0]   reg_be,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  take_stb,
  output logic [LVL_W-1:0]      take_lvl,
  output logic                  use_rst_vec,
  output logic                  dbl_fault,
  output logic                  ret_illegal,
  output logic [CUR_W-1:0]      cur_lvl
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_OVR   = IDX_W'(RS_OVR);
  localparam logic [IDX_W-1:0] IDX_MASK  = IDX_W'(RS_MASK);
  localparam logic [IDX_W-1:0] IDX_PEND  = IDX_W'(RS_PEND);
  localparam logic [IDX_W-1:0] IDX_LATCH = IDX_W'(RS_LATCH);
  localparam logic [IDX_W-1:0] IDX_PRIO  = IDX_W'(RS_PRIO);

  logic [NUM_LVL-1:0] ovr_q, mask_q, pend_q, ilat_q, prio_q;
  logic [NUM_LVL-1:0] ovr_d, mask_d, pend_d, ilat_d, prio_d;
  logic               chk_q, chk_d;

  // access decode: full-word, aligned only
  logic             acc_ok, wr_ok;
  logic [IDX_W-1:0] word_idx;
  logic             unused_hi;
  assign acc_ok    = (&reg_be) && (reg_addr[1:0] == 2'b00);
  assign wr_ok     = reg_wr && acc_ok;
  assign word_idx  = reg_addr[ADDR_W-1:2];
  assign unused_hi = ^reg_wdata[DATA_W-1:NUM_LVL];

  // candidate selection
  logic [NUM_LVL-1:0] req_eff;
  logic               req_hit, sel_hit, nxt_hit;
  logic [LVL_W-1:0]   req_idx, sel_idx, nxt_idx;
  assign req_eff = evt_req & ~(NUM_LVL'(1) << GDIS_IDX);

  evt_prio_enc #(.W(NUM_LVL), .IW(LVL_W)) u_req_enc (.vec(req_eff),         .hit(req_hit), .idx(req_idx));
  evt_prio_enc #(.W(NUM_LVL), .IW(LVL_W)) u_sel_enc (.vec(ilat_q & mask_q), .hit(sel_hit), .idx(sel_idx));

  logic [CUR_W-1:0] sel_x;
  logic             chk_ok, cand_valid, take, dfault;
  logic [LVL_W-1:0] cand_lvl;
  assign sel_x      = {1'b0, sel_idx};
  assign chk_ok     = chk_q && !pend_q[GDIS_IDX] && sel_hit &&
                      (sel_x < cur_lvl || (self_nest_en && sel_x == cur_lvl));
  assign cand_valid = req_hit || chk_ok;
  assign cand_lvl   = req_hit ? req_idx : sel_idx;

  evt_take_rule u_rule (
    .valid(cand_valid), .lvl(cand_lvl), .cur(cur_lvl), .gdis(pend_q[GDIS_IDX]),
    .mask_bit(mask_q[cand_lvl]), .snen(self_nest_en), .take(take), .dfault(dfault)
  );

  // return legality against the current level
  logic ret_ok;
  always_comb begin
    if (cur_lvl == USER_LVL)   ret_ok = 1'b0;
    else if (ret_lvl == LV_EMU) ret_ok = (cur_lvl == {1'b0, LV_EMU});
    else if (ret_lvl == LV_NMI) ret_ok = (cur_lvl == {1'b0, LV_NMI});
    else if (ret_lvl == LV_EXC) ret_ok = (cur_lvl == {1'b0, LV_EXC});
    else if (ret_lvl == LV_GDIS) ret_ok = 1'b0;
    else ret_ok = !(cur_lvl == {1'b0, LV_EMU} || cur_lvl == {1'b0, LV_NMI} ||
                    cur_lvl == {1'b0, LV_EXC});
  end

  // next state
  always_comb begin
    ovr_d  = ovr_q;
    mask_d = mask_q;
    prio_d = prio_q;
    pend_d = pend_q;
    ilat_d = ilat_q | req_eff;
    chk_d  = req_hit;
    if (wr_ok) begin
      case (word_idx)
        IDX_OVR:   ovr_d  = reg_wdata[NUM_LVL-1:0];
        IDX_MASK:  begin
          mask_d = (reg_wdata[NUM_LVL-1:0] & ~FIXED_MASK) | FIXED_MASK;
          chk_d  = 1'b1;
        end
        IDX_LATCH: ilat_d = ilat_d & ~(reg_wdata[NUM_LVL-1:0] & LATCH_CLR_OK);
        IDX_PRIO:  prio_d = reg_wdata[NUM_LVL-1:0] & FIXED_MASK;
        default:   ;
      endcase
    end
    if (ret_cmd) begin
      pend_d[EMU_IDX] = 1'b0;
      if (ret_ok) begin
        if (!ret_addr_lsb) pend_d[ret_lvl] = 1'b0;
        if (ret_lvl >= LV_HWE || ret_lvl == LV_RST) pend_d[GDIS_IDX] = 1'b0;
      end
      chk_d = 1'b1;
    end
    if (push_cmd) begin
      pend_d[GDIS_IDX] = 1'b0;
      chk_d = 1'b1;
    end
    if (pop_cmd) pend_d[GDIS_IDX] = 1'b1;
    if (take) begin
      pend_d[cand_lvl] = 1'b1;
      ilat_d[cand_lvl] = 1'b0;
      if (cand_lvl >= LV_HWE) pend_d[GDIS_IDX] = 1'b1;
    end
  end

  evt_prio_enc #(.W(NUM_LVL), .IW(LVL_W)) u_cur_enc (.vec(pend_d & ~NOT_A_LEVEL), .hit(nxt_hit), .idx(nxt_idx));

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (acc_ok) begin
      case (word_idx)
        IDX_OVR:   rd_mux = DATA_W'(ovr_q);
        IDX_MASK:  rd_mux = DATA_W'(mask_q);
        IDX_PEND:  rd_mux = DATA_W'(pend_q);
        IDX_LATCH: rd_mux = DATA_W'(ilat_q);
        IDX_PRIO:  rd_mux = DATA_W'(prio_q);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q       <= '0;
      mask_q      <= FIXED_MASK;
      pend_q      <= PEND_RESET;
      ilat_q      <= '0;
      prio_q      <= '0;
      chk_q       <= 1'b0;
      cur_lvl     <= {1'b0, LV_RST};
      take_stb    <= 1'b0;
      take_lvl    <= '0;
      use_rst_vec <= 1'b0;
      dbl_fault   <= 1'b0;
      ret_illegal <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      ovr_q       <= ovr_d;
      mask_q      <= mask_d;
      pend_q      <= pend_d;
      ilat_q      <= ilat_d;
      prio_q      <= prio_d;
      chk_q       <= chk_d;
      cur_lvl     <= nxt_hit ? {1'b0, nxt_idx} : USER_LVL;
      take_stb    <= take;
      if (take) take_lvl <= cand_lvl;
      use_rst_vec <= take && ovr_q[cand_lvl] && OVR_VALID[cand_lvl];
      dbl_fault   <= dfault;
      ret_illegal <= ret_cmd && !ret_ok;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R9: a take leaves its in-service bit set
  a_r9_take_sets_pending: assert property (@(posedge clk) disable iff (rst)
    take_stb |-> pend_q[take_lvl]);
  // R9: taking level 5 or above raises the global disable flag
  a_r9_high_take_gdis: assert property (@(posedge clk) disable iff (rst)
    (take_stb && take_lvl >= LV_HWE) |-> pend_q[GDIS_IDX]);
  // R8: a level 5+ take needs the flag clear or user level one cycle earlier
  a_r8_gdis_blocks: assert property (@(posedge clk) disable iff (rst)
    (take_stb && take_lvl >= LV_HWE) |-> $past(!pend_q[GDIS_IDX] || cur_lvl == USER_LVL));
  // R7: a double fault never coincides with a take
  a_r7_fault_no_take: assert property (@(posedge clk) disable iff (rst)
    dbl_fault |-> !take_stb);
  // R13: a pop leaves the global disable flag set
  a_r13_pop_sets_gdis: assert property (@(posedge clk) disable iff (rst)
    pop_cmd |=> pend_q[GDIS_IDX]);
  // R5: the reported level is in service
  a_r5_cur_in_service: assert property (@(posedge clk) disable iff (rst)
    (cur_lvl != USER_LVL) |-> pend_q[cur_lvl[LVL_W-1:0]]);
endmodule

// File: tb/evt_ctrl_tb_top.sv
module evt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_req = '0;
  logic        self_nest_en = 1'b0;
  logic        ret_cmd = 1'b0;
  logic [3:0]  ret_lvl = '0;
  logic        ret_addr_lsb = 1'b0;
  logic        push_cmd = 1'b0;
  logic        pop_cmd = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = 4'hF;
  logic [31:0] reg_rdata;
  logic        take_stb, use_rst_vec, dbl_fault, ret_illegal;
  logic [3:0]  take_lvl;
  logic [4:0]  cur_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_req(evt_req), .self_nest_en(self_nest_en),
    .ret_cmd(ret_cmd), .ret_lvl(ret_lvl), .ret_addr_lsb(ret_addr_lsb),
    .push_cmd(push_cmd), .pop_cmd(pop_cmd), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .take_stb(take_stb), .take_lvl(take_lvl), .use_rst_vec(use_rst_vec),
    .dbl_fault(dbl_fault), .ret_illegal(ret_illegal), .cur_lvl(cur_lvl)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_be = 4'hF;
  endtask

  task automatic rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
    reg_addr = a; reg_be = be; reg_rd = 1'b1;
    tick();
    d = reg_rdata;
    reg_rd = 1'b0; reg_be = 4'hF;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, 4'hF, v);
    chk(tag, v, exp);
  endtask

  task automatic req(input logic [15:0] v);
    evt_req = v;
    tick();
    evt_req = '0;
  endtask

  task automatic ret(input logic [3:0] l, input logic lsb);
    ret_lvl = l; ret_addr_lsb = lsb; ret_cmd = 1'b1;
    tick();
    ret_cmd = 1'b0; ret_addr_lsb = 1'b0;
  endtask

  task automatic push();
    push_cmd = 1'b1; tick(); push_cmd = 1'b0;
  endtask

  task automatic pop();
    pop_cmd = 1'b1; tick(); pop_cmd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cur_lvl", cur_lvl, 1);
    chk("R1 take_stb", take_stb, 0);
    chk("R1 dbl_fault", dbl_fault, 0);
    chk("R1 ret_illegal", ret_illegal, 0);
    rd_chk("R1 R2 override", 5'h00, 32'h0);
    rd_chk("R1 R2 mask", 5'h04, 32'h1F);
    rd_chk("R1 R2 pending", 5'h08, 32'h12);
    rd_chk("R1 R2 latch", 5'h0C, 32'h0);
    rd_chk("R1 R2 priority", 5'h10, 32'h0);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_FFFF, 4'b0011);
    rd_chk("R2 partial write ignored", 5'h04, 32'h1F);
    rd(5'h08, 4'b0111, v);
    chk("R2 partial read zero", v, 32'h0);
  endtask

  task automatic t_blocked_at_reset();
    req(16'h0090);
    chk("R8 no take under disable", take_stb, 0);
    tick();
    chk("R8 deferred check blocked", take_stb, 0);
    rd_chk("R6 bit4 dropped, level 7 latched", 5'h0C, 32'h80);
  endtask

  task automatic t_leave_reset();
    ret(4'd1, 1'b0);
    chk("R11 legal return", ret_illegal, 0);
    chk("R11 R5 user level", cur_lvl, 16);
    tick();
    chk("R8 masked latch not taken", take_stb, 0);
    rd_chk("R11 pending cleared", 5'h08, 32'h0);
  endtask

  task automatic t_mask_take();
    wr(5'h04, 32'h0000_FF80, 4'hF);
    chk("R10 no take at write edge", take_stb, 0);
    tick();
    chk("R10 deferred take", take_stb, 1);
    chk("R9 take level", take_lvl, 7);
    chk("R9 no reset vector", use_rst_vec, 0);
    chk("R5 cur level 7", cur_lvl, 7);
    tick();
    chk("R9 strobe one cycle", take_stb, 0);
    rd_chk("R3 mask fixed bits", 5'h04, 32'hFF9F);
    rd_chk("R9 pending with disable", 5'h08, 32'h90);
    rd_chk("R9 latch cleared", 5'h0C, 32'h0);
  endtask

  task automatic t_gdis_block();
    req(16'h0200);
    chk("R8 level 9 blocked by disable", take_stb, 0);
    rd_chk("R8 latch kept", 5'h0C, 32'h200);
  endtask

  task automatic t_push_mask();
    push();
    rd_chk("R13 push clears flag", 5'h08, 32'h80);
    req(16'h0040);
    chk("R8 masked level 6", take_stb, 0);
    rd_chk("R8 latch keeps masked", 5'h0C, 32'h240);
    wr(5'h04, 32'h0000_FFE0, 4'hF);
    tick();
    chk("R10 take after unmask", take_stb, 1);
    chk("R10 lowest latched", take_lvl, 6);
    chk("R5 cur level 6", cur_lvl, 6);
    rd_chk("R9 pending nested", 5'h08, 32'hD0);
  endtask

  task automatic t_push_pop();
    push();
    rd_chk("R13 push", 5'h08, 32'hC0);
    pop();
    rd_chk("R13 pop sets flag", 5'h08, 32'hD0);
  endtask

  task automatic t_self_nest();
    push();
    tick();
    self_nest_en = 1'b1;
    req(16'h0040);
    chk("R14 self nest taken", take_stb, 1);
    chk("R14 self nest level", take_lvl, 6);
    rd_chk("R14 pending", 5'h08, 32'hD0);
    self_nest_en = 1'b0;
    push();
    tick();
    req(16'h0040);
    chk("R14 no nest when disabled", take_stb, 0);
    rd_chk("R14 latched instead", 5'h0C, 32'h240);
  endtask

  task automatic t_latch_w1c();
    wr(5'h0C, 32'h0000_0040, 4'hF);
    rd_chk("R4 clear one bit", 5'h0C, 32'h200);
    wr(5'h0C, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R4 clear all allowed", 5'h0C, 32'h0);
  endtask

  task automatic t_lsb_return();
    ret(4'd6, 1'b1);
    chk("R11 nested return legal", ret_illegal, 0);
    chk("R11 nested return keeps level", cur_lvl, 6);
    rd_chk("R11 pending kept", 5'h08, 32'hC0);
    ret(4'd6, 1'b0);
    chk("R11 return to 7", cur_lvl, 7);
    ret(4'd7, 1'b0);
    chk("R11 return to user", cur_lvl, 16);
    rd_chk("R11 pending empty", 5'h08, 32'h0);
  endtask

  task automatic t_override();
    wr(5'h00, 32'h0000_0120, 4'hF);
    rd_chk("R2 override stored", 5'h00, 32'h120);
    req(16'h0100);
    chk("R9 take at user level", take_stb, 1);
    chk("R9 level 8", take_lvl, 8);
    chk("R9 reset vector", use_rst_vec, 1);
    chk("R5 cur 8", cur_lvl, 8);
    tick();
    chk("R9 reset vector one cycle", use_rst_vec, 0);
  endtask

  task automatic t_dfault();
    req(16'h0008);
    chk("R7 level 3 taken under disable", take_stb, 1);
    chk("R7 level 3", take_lvl, 3);
    chk("R9 override ignored below 7", use_rst_vec, 0);
    chk("R5 cur 3", cur_lvl, 3);
    req(16'h0008);
    chk("R7 double fault", dbl_fault, 1);
    chk("R7 no take", take_stb, 0);
    tick();
    chk("R7 fault one cycle", dbl_fault, 0);
    rd_chk("R7 latch kept", 5'h0C, 32'h08);
    req(16'h0004);
    chk("R7 level 2 taken", take_lvl, 2);
    chk("R5 cur 2", cur_lvl, 2);
  endtask

  task automatic t_illegal();
    ret(4'd3, 1'b0);
    chk("R12 exception return at 2", ret_illegal, 1);
    tick();
    chk("R12 pulse one cycle", ret_illegal, 0);
    rd_chk("R12 state unchanged", 5'h08, 32'h11C);
    ret(4'd9, 1'b0);
    chk("R12 general return at 2", ret_illegal, 1);
    ret(4'd2, 1'b0);
    chk("R12 nmi return legal", ret_illegal, 0);
    chk("R11 cur 3", cur_lvl, 3);
    rd_chk("R11 flag kept for level 2", 5'h08, 32'h118);
  endtask

  task automatic t_top_levels();
    req(16'h0002);
    chk("R6 level 1 taken", take_lvl, 1);
    chk("R6 cur 1", cur_lvl, 1);
    req(16'h0001);
    chk("R6 level 0 taken", take_stb, 1);
    chk("R6 level 0", take_lvl, 0);
    chk("R5 emulation ignored", cur_lvl, 1);
    rd_chk("R6 pending", 5'h08, 32'h11B);
    ret(4'd0, 1'b0);
    chk("R12 emulation return illegal", ret_illegal, 1);
    rd_chk("R11 emulation bit cleared", 5'h08, 32'h11A);
  endtask

  task automatic t_ignored_writes();
    wr(5'h08, 32'h0, 4'hF);
    rd_chk("R3 pending write ignored", 5'h08, 32'h11A);
    wr(5'h10, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 priority low bits", 5'h10, 32'h1F);
    wr(5'h04, 32'h0, 4'hF);
    rd_chk("R3 mask keeps fixed", 5'h04, 32'h1F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_partial();
    t_blocked_at_reset();
    t_leave_reset();
    t_mask_take();
    t_gdis_block();
    t_push_mask();
    t_push_pop();
    t_self_nest();
    t_latch_w1c();
    t_lsb_return();
    t_override();
    t_dfault();
    t_illegal();
    t_top_levels();
    t_ignored_writes();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule